// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator

This block gathers sixteen external interrupt request lines into a single active-high level request for a host processor. Each input is brought into the clock domain through a two-stage synchronizer and then latched into a sticky pending register. A separate enable mask gates the pending bits. The output request is high while any pending bit is also enabled.

Software reaches the block through a small 16-bit synchronous register port. It can read the pending bits and clear any of them by writing ones. It can read the live, unlatched input levels. It changes the enable mask only through two write-one addresses, one that enables and one that disables. Reading the enable-set address returns the current mask, so a driver never has to read, modify and write the mask.

Top module: `irqx_expander`

## Requirements
- R1: After reset the enable mask and the pending bits are all zero, `irq_out` is low and `rdata` is zero.
- R2: Input n is taken through two synchronizer flops. Its pending bit (bit n) is set on the third rising edge after the input goes high. The bit stays set after the input returns low.
- R3: A write to offset 0x16 clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. A pending bit whose synchronized input is still high stays set through the clear.
- R4: A read of offset 0x18 returns the synchronized level of every input, unlatched and unmasked.
- R5: A write to offset 0x1A sets the enable bit for each data bit that is 1; bits written 0 have no effect. A read of 0x1A returns the 16-bit enable mask.
- R6: A write to offset 0x1C clears the enable bit for each data bit that is 1; bits written 0 have no effect. If an enable-set and an enable-clear reach the same bit in one cycle, the clear wins.
- R7: `irq_out` is high exactly while some bit is both pending and enabled. A masked pending bit leaves it low, and it rises on the edge that enables that bit. It falls only on a cycle that takes a register write.
- R8: Reads are registered. `rdata` shows the addressed value after the rising edge that samples `rd_en`, and is zero after any edge where `rd_en` is low. Offsets other than 0x16, 0x18 and 0x1A, including 0x1C, read as zero.
- R9: With all inputs low, writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves every line disabled, nothing pending and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 16 | Asynchronous interrupt request levels, bit n is line n |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe for `wdata` at `addr` |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Read strobe for `addr` |
| rdata | output | 16 | Read data, valid one cycle after `rd_en` |
| irq_out | output | 1 | Combined active-high interrupt request |

## Verification
The hard case to reach is a clear arriving while its source is still active. The bench holds a line high across a write-one-to-clear and then confirms that the bit survives the clear. The masked-pending case is also hard to see from the ports. For each of the sixteen lines, the bench latches a pulse, releases the input and confirms the output stays low. It then enables just that bit and samples the output on the next half cycle. The sweep also runs the mask through writes whose zero bits must do nothing. It reads every even offset to confirm the unmapped ones return zero while state is pending.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int ADDR_W = 8;
  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFF_PEND  = 8'h16;
  localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_ENSET = 8'h1A;
  localparam logic [ADDR_W-1:0] OFF_ENCLR = 8'h1C;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_n;

  always_comb begin
    pipe_n = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_n;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/irqx_core.sv
module irqx_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pend_clr,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  output logic [W-1:0] pend,
  output logic [W-1:0] en
);
  logic [W-1:0] pend_q, pend_n;
  logic [W-1:0] en_q, en_n;
  logic         pend_ce, en_ce;

  always_comb begin
    pend_ce = (|lvl) | (|pend_clr);
    pend_n  = (pend_q & ~pend_clr) | lvl;
    en_ce   = (|en_set) | (|en_clr);
    en_n    = (en_q | en_set) & ~en_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      if (pend_ce) pend_q <= pend_n;
      if (en_ce)   en_q   <= en_n;
    end
  end

  assign pend = pend_q;
  assign en   = en_q;

  // R2
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(lvl)) == '0));

  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_clr) & ~$past(lvl) & pend_q) == '0));

  // R6
  en_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(en_clr) & en_q) == '0));

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(en_set) & ~$past(en_clr) & ~en_q) == '0));
endmodule

// File: rtl/irqx_regif.sv
module irqx_regif
  import irqx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wdata,
  input  logic              rd_en,
  input  logic [W-1:0]      pend,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      en,
  output logic [W-1:0]      pend_clr,
  output logic [W-1:0]      en_set,
  output logic [W-1:0]      en_clr,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q, rdata_n;

  always_comb begin
    pend_clr = (wr_en && addr == OFF_PEND)  ? wdata : '0;
    en_set   = (wr_en && addr == OFF_ENSET) ? wdata : '0;
    en_clr   = (wr_en && addr == OFF_ENCLR) ? wdata : '0;
    case (addr)
      OFF_PEND:  rd_mux = pend;
      OFF_LEVEL: rd_mux = lvl;
      OFF_ENSET: rd_mux = en;
      default:   rd_mux = '0;
    endcase
    rdata_n = rd_en ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign rdata = rdata_q;

  // R8
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

  // R8
  rdata_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != OFF_PEND && addr != OFF_LEVEL && addr != OFF_ENSET)
      |=> (rdata == '0));
endmodule

// File: rtl/irqx_expander.sv
module irqx_expander
  import irqx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      irq_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wdata,
  input  logic              rd_en,
  output logic [W-1:0]      rdata,
  output logic              irq_out
);
  logic [1:0]   rst_pipe_q;
  logic         core_rst_n;
  logic [W-1:0] lvl, pend, en, pend_clr, en_set, en_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  irqx_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(core_rst_n), .d(irq_in), .q(lvl)
  );

  irqx_core #(.W(W)) u_core (
    .clk(clk), .rst_n(core_rst_n), .lvl(lvl),
    .pend_clr(pend_clr), .en_set(en_set), .en_clr(en_clr),
    .pend(pend), .en(en)
  );

  irqx_regif #(.W(W)) u_regif (
    .clk(clk), .rst_n(core_rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .pend(pend), .lvl(lvl), .en(en),
    .pend_clr(pend_clr), .en_set(en_set), .en_clr(en_clr), .rdata(rdata)
  );

  assign irq_out = |(pend & en);

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(irq_out) |-> $past(wr_en));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (en == '0) |-> !irq_out);
endmodule

// File: tb/test_irqx_expander.sv
module test_irqx_expander;
  localparam int W = 16;
  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  irq_in;
  logic [7:0]    addr;
  logic          wr_en, rd_en;
  logic [W-1:0]  wdata, rdata;
  logic          irq_out;
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  irqx_expander #(.W(W)) i_irqx_expander (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] bit_n;
    rst_n = 1'b0; irq_in = '0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);
    // R1 reset state
    chk("R1 irq_out", {15'd0, irq_out}, '0);
    chk("R1 rdata", rdata, '0);
    rd(8'h16, v); chk("R1 pending", v, '0);
    rd(8'h1A, v); chk("R1 enable", v, '0);

    for (int n = 0; n < W; n++) begin
      bit_n = W'(1) << n;
      @(negedge clk); irq_in = bit_n;
      settle(2);
      rd(8'h18, v); chk("R4 level high", v, bit_n);
      rd(8'h16, v); chk("R2 latched", v, bit_n);
      chk("R7 masked stays low", {15'd0, irq_out}, '0);
      @(negedge clk); irq_in = '0;
      settle(3);
      rd(8'h16, v); chk("R2 sticky", v, bit_n);
      rd(8'h18, v); chk("R4 level low", v, '0);
      chk("R7 masked after drop", {15'd0, irq_out}, '0);
      wr(8'h1A, bit_n);
      chk("R7 rises on enable", {15'd0, irq_out}, 16'd1);
      rd(8'h1A, v); chk("R5 mask readback", v, bit_n);
      wr(8'h16, ~bit_n);
      rd(8'h16, v); chk("R3 zero bits keep", v, bit_n);
      wr(8'h1C, ~bit_n);
      rd(8'h1A, v); chk("R6 zero bits keep", v, bit_n);
      chk("R7 still high", {15'd0, irq_out}, 16'd1);
      wr(8'h1A, ~bit_n);
      rd(8'h1A, v); chk("R5 set others", v, 16'hFFFF);
      wr(8'h1C, ~bit_n);
      rd(8'h1A, v); chk("R6 clear others", v, bit_n);
      wr(8'h1C, bit_n);
      chk("R6 disabled drops irq", {15'd0, irq_out}, '0);
      rd(8'h1A, v); chk("R6 mask empty", v, '0);
      wr(8'h16, bit_n);
      rd(8'h16, v); chk("R3 cleared", v, '0);
    end

    // R3 clear while the source is still high
    for (int n = 0; n < W; n += 5) begin
      bit_n = W'(1) << n;
      @(negedge clk); irq_in = bit_n;
      settle(3);
      wr(8'h16, bit_n);
      rd(8'h16, v); chk("R3 active source survives clear", v, bit_n);
      @(negedge clk); irq_in = '0;
      settle(3);
      wr(8'h16, bit_n);
      rd(8'h16, v); chk("R3 cleared after release", v, '0);
    end

    // R8 unmapped offsets read zero while state is live
    @(negedge clk); irq_in = 16'hA5C3;
    settle(3);
    wr(8'h1A, 16'h00FF);
    for (int a = 0; a < 256; a += 2) begin
      rd(8'(a), v);
      if (a == 8'h16)      chk("R8 pending read", v, 16'hA5C3);
      else if (a == 8'h18) chk("R8 level read", v, 16'hA5C3);
      else if (a == 8'h1A) chk("R8 enable read", v, 16'h00FF);
      else                 chk("R8 unmapped zero", v, '0);
    end
    @(negedge clk);
    chk("R8 idle rdata zero", rdata, '0);

    // R9 shutdown sequence
    @(negedge clk); irq_in = '0;
    settle(3);
    wr(8'h1A, 16'hFFFF);
    chk("R7 all enabled high", {15'd0, irq_out}, 16'd1);
    wr(8'h1C, 16'hFFFF);
    wr(8'h16, 16'hFFFF);
    chk("R9 irq low", {15'd0, irq_out}, '0);
    rd(8'h1A, v); chk("R9 all disabled", v, '0);
    rd(8'h16, v); chk("R9 nothing pending", v, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule